// File: doc/BRIEF.md
# Asynchronous NAND Bus Cycle Timer

This block shapes the control strobes of a single asynchronous access on a chip-select style flash bus. A host side issues a request carrying a direction flag and, for writes, a data word. The block then runs a tick counter at the interface clock. It drives chip enable, address-latch valid, output enable, write enable and the data-bus drive enable. Each strobe is active inside a programmable window of whole clock periods.

Reads sample the data bus at a programmable access tick and present the captured word when the access completes. Writes hold the latched data word on the bus for the whole cycle. After each access the block can hold off the next request. The hold-off covers an idle gap between accesses to the same select, which an optimized-access input can remove, and a turnaround delay after reads. Every timing value is a live input, so the block is configured by wiring it to registers elsewhere.

Top module: `nct_top`

## Requirements
- R1: After reset the bus is quiet (`ce_n`=1, `ale`=0, `oe_n`=1, `we_n`=1, `dq_oe`=0), `done`=0 and `ready`=1.
- R2: Tick t of an access occupies the t-th clock cycle after acceptance, starting at t=0. `ce_n` is 0 for ticks 0 up to (not including) its off tick, which is `t_ce_off_rd` for reads and `t_ce_off_wr` for writes.
- R3: `ale` is 1 for ticks from `t_ale_on` up to its off tick, which is `t_ale_off_rd` for reads and `t_ale_off_wr` for writes.
- R4: In reads, `oe_n` is 0 for ticks `t_oe_on` up to `t_oe_off` and `we_n` stays 1. In writes, `we_n` is 0 for ticks `t_we_on` up to `t_we_off` and `oe_n` stays 1.
- R5: A strobe whose off tick is less than or equal to its on tick stays inactive for the whole access.
- R6: An access lasts `t_rd_cycle` or `t_wr_cycle` ticks. `done` is 1 for exactly the one cycle after the last tick, with all strobes inactive. `ready` is 0 from the cycle after acceptance through the last tick.
- R7: On a read, `rdata` takes the value `dq_in` had during tick `t_rd_access`-1 and shows it from tick `t_rd_access` on. `rdata` does not change while the block is idle. This requires 1 ≤ `t_rd_access` ≤ `t_rd_cycle`.
- R8: On a write, `dq_oe` is 1 for every tick of the access and `dq_out` carries the accepted `req_wdata`.
- R9: A request is accepted only on a clock edge where `ready` is 1. A `req_valid` pulse while busy starts no access.
- R10: After an access the block waits W cycles, where W = max(G, T). G is `t_gap` when `gap_en`=1 and `opt_access`=0, else 0. T is `t_turn` after a read, else 0. `ready` is 1 in the `done` cycle when W=0, otherwise first W cycles after the `done` cycle begins. This leaves at least W+1 quiet cycles before the next tick 0.
- R11: With `opt_access`=1 the same-select gap is dropped, so back-to-back writes follow with W=0 even when `gap_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; one tick per period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data word |
| t_ce_off_rd | input | TW | Chip-enable off tick, reads |
| t_ce_off_wr | input | TW | Chip-enable off tick, writes |
| t_ale_on | input | TW | Address-latch valid on tick |
| t_ale_off_rd | input | TW | Address-latch valid off tick, reads |
| t_ale_off_wr | input | TW | Address-latch valid off tick, writes |
| t_oe_on | input | TW | Output-enable on tick |
| t_oe_off | input | TW | Output-enable off tick |
| t_we_on | input | TW | Write-enable on tick |
| t_we_off | input | TW | Write-enable off tick |
| t_rd_cycle | input | TW | Read access length in ticks |
| t_wr_cycle | input | TW | Write access length in ticks |
| t_rd_access | input | TW | Read capture tick |
| t_gap | input | TW | Same-select idle gap |
| gap_en | input | 1 | Enables the idle gap |
| opt_access | input | 1 | Optimized access: drops the idle gap |
| t_turn | input | TW | Turnaround after a read |
| ready | output | 1 | Block idle, request may be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last captured read word |
| dq_in | input | DW | Data bus input |
| dq_out | output | DW | Data bus output |
| dq_oe | output | 1 | Data bus drive enable |
| ce_n | output | 1 | Chip enable, active low |
| ale | output | 1 | Address-latch valid, active high |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The assertions assume the timing inputs stay constant while an access or its hold-off is running. They also assume every cycle length is at least 1 and the read capture tick lies between 1 and the read cycle length. The stimulus changes timing values only between accesses, when `ready` is high, and every programmed cycle length is at least 4. The expected waveform of each access is built tick by tick from the programmed values and compared in the exact cycle it should appear.

// File: rtl/nct_pkg.sv
package nct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } nct_state_e;

  // strobe slots
  localparam int NSTB   = 5;
  localparam int SI_CE  = 0;
  localparam int SI_ALE = 1;
  localparam int SI_OE  = 2;
  localparam int SI_WE  = 3;
  localparam int SI_DQ  = 4;
  // 1 = strobe is active low
  localparam logic [NSTB-1:0] STB_ACT_LOW = 5'b01101;
endpackage

// File: rtl/nct_window.sv
module nct_window #(
  parameter int   TW      = 5,
  parameter logic ACT_LOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          live,
  input  logic          en,
  input  logic [TW-1:0] tick,
  input  logic [TW-1:0] on_t,
  input  logic [TW-1:0] off_t,
  output logic          strobe
);
  logic hit;

  // active when on_t <= tick < off_t; empty window if off_t <= on_t
  always_comb hit = live && en && (tick >= on_t) && (tick < off_t);

  always_ff @(posedge clk) begin
    if (rst) strobe <= ACT_LOW;
    else     strobe <= ACT_LOW ^ hit;
  end
endmodule

// File: rtl/nct_wait.sv
module nct_wait #(
  parameter int TW = 5
) (
  input  logic [TW-1:0] gap_len,
  input  logic          gap_en,
  input  logic          opt_access,
  input  logic [TW-1:0] turn_len,
  input  logic          was_read,
  output logic [TW-1:0] wait_len
);
  logic [TW-1:0] g, t;

  always_comb begin
    g        = (gap_en && !opt_access) ? gap_len : '0;
    t        = was_read ? turn_len : '0;
    wait_len = (g > t) ? g : t;
  end
endmodule

// File: rtl/nct_seq.sv
module nct_seq
  import nct_pkg::*;
#(
  parameter int TW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  input  logic [TW-1:0] rd_cycle,
  input  logic [TW-1:0] wr_cycle,
  input  logic [TW-1:0] rd_access,
  input  logic [TW-1:0] gap_len,
  input  logic          gap_en,
  input  logic          opt_access,
  input  logic [TW-1:0] turn_len,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] wdata_q,
  output logic          live_nxt,
  output logic [TW-1:0] tick_nxt,
  output logic          wr_nxt
);
  nct_state_e    state;
  logic [TW-1:0] cnt, wcnt, cyc_sel, wait_len;
  logic          op_wr, accept, last, capture;

  nct_wait #(.TW(TW)) u_wait (
    .gap_len   (gap_len),
    .gap_en    (gap_en),
    .opt_access(opt_access),
    .turn_len  (turn_len),
    .was_read  (!op_wr),
    .wait_len  (wait_len)
  );

  always_comb begin
    cyc_sel  = op_wr ? wr_cycle : rd_cycle;
    accept   = (state == ST_IDLE) && req_valid;
    last     = (state == ST_RUN) && (cnt == cyc_sel - 1'b1);
    capture  = (state == ST_RUN) && !op_wr && (cnt + 1'b1 == rd_access);
    live_nxt = accept || ((state == ST_RUN) && !last);
    tick_nxt = accept ? '0 : cnt + 1'b1;
    wr_nxt   = accept ? req_write : op_wr;
    ready    = (state == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wcnt    <= '0;
      op_wr   <= 1'b0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (capture) rdata <= dq_in;
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_RUN;
          cnt     <= '0;
          op_wr   <= req_write;
          wdata_q <= req_wdata;
        end
        ST_RUN: begin
          if (last) begin
            done <= 1'b1;
            wcnt <= wait_len;
            state <= (wait_len == '0) ? ST_IDLE : ST_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (wcnt <= 1) state <= ST_IDLE;
          else           wcnt  <= wcnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nct_top.sv
module nct_top
  import nct_pkg::*;
#(
  parameter int TW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] t_ce_off_rd,
  input  logic [TW-1:0] t_ce_off_wr,
  input  logic [TW-1:0] t_ale_on,
  input  logic [TW-1:0] t_ale_off_rd,
  input  logic [TW-1:0] t_ale_off_wr,
  input  logic [TW-1:0] t_oe_on,
  input  logic [TW-1:0] t_oe_off,
  input  logic [TW-1:0] t_we_on,
  input  logic [TW-1:0] t_we_off,
  input  logic [TW-1:0] t_rd_cycle,
  input  logic [TW-1:0] t_wr_cycle,
  input  logic [TW-1:0] t_rd_access,
  input  logic [TW-1:0] t_gap,
  input  logic          gap_en,
  input  logic          opt_access,
  input  logic [TW-1:0] t_turn,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          ce_n,
  output logic          ale,
  output logic          oe_n,
  output logic          we_n
);
  logic          live_nxt, wr_nxt;
  logic [TW-1:0] tick_nxt;
  logic [TW-1:0] on_v  [NSTB];
  logic [TW-1:0] off_v [NSTB];
  logic [NSTB-1:0] en_v, stb_q;

  nct_seq #(.TW(TW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .dq_in     (dq_in),
    .rd_cycle  (t_rd_cycle),
    .wr_cycle  (t_wr_cycle),
    .rd_access (t_rd_access),
    .gap_len   (t_gap),
    .gap_en    (gap_en),
    .opt_access(opt_access),
    .turn_len  (t_turn),
    .ready     (ready),
    .done      (done),
    .rdata     (rdata),
    .wdata_q   (dq_out),
    .live_nxt  (live_nxt),
    .tick_nxt  (tick_nxt),
    .wr_nxt    (wr_nxt)
  );

  always_comb begin
    on_v[SI_CE]  = '0;
    off_v[SI_CE] = wr_nxt ? t_ce_off_wr : t_ce_off_rd;
    en_v[SI_CE]  = 1'b1;
    on_v[SI_ALE]  = t_ale_on;
    off_v[SI_ALE] = wr_nxt ? t_ale_off_wr : t_ale_off_rd;
    en_v[SI_ALE]  = 1'b1;
    on_v[SI_OE]  = t_oe_on;
    off_v[SI_OE] = t_oe_off;
    en_v[SI_OE]  = !wr_nxt;
    on_v[SI_WE]  = t_we_on;
    off_v[SI_WE] = t_we_off;
    en_v[SI_WE]  = wr_nxt;
    on_v[SI_DQ]  = '0;
    off_v[SI_DQ] = t_wr_cycle;
    en_v[SI_DQ]  = wr_nxt;
  end

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    nct_window #(.TW(TW), .ACT_LOW(STB_ACT_LOW[g])) u_win (
      .clk   (clk),
      .rst   (rst),
      .live  (live_nxt),
      .en    (en_v[g]),
      .tick  (tick_nxt),
      .on_t  (on_v[g]),
      .off_t (off_v[g]),
      .strobe(stb_q[g])
    );
  end

  assign ce_n  = stb_q[SI_CE];
  assign ale   = stb_q[SI_ALE];
  assign oe_n  = stb_q[SI_OE];
  assign we_n  = stb_q[SI_WE];
  assign dq_oe = stb_q[SI_DQ];
endmodule

// File: rtl/nct_checker.sv
module nct_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          ready,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic          ce_n,
  input logic          ale,
  input logic          oe_n,
  input logic          we_n,
  input logic          dq_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ce_n && !ale && oe_n && we_n && !dq_oe)); // R1

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n)); // R4

  AST_DQ_NOT_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && !oe_n)); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(ready)); // R6

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> $stable(rdata)); // R7

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid) |=> !ready); // R9
endmodule

bind nct_top nct_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .ready    (ready),
  .done     (done),
  .rdata    (rdata),
  .ce_n     (ce_n),
  .ale      (ale),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .dq_oe    (dq_oe)
);

// File: tb/nct_top_tb_top.sv
module nct_top_tb_top;
  localparam int TW = 5;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [TW-1:0] ce_rd, ce_wr, ale_on, ale_rd, ale_wr, oe_on, oe_off, we_on, we_off;
  logic [TW-1:0] rd_cyc, wr_cyc, rd_acc, gap, turn;
  logic          gap_en, opt;
  logic          ready, done, dq_oe, ce_n, ale, oe_n, we_n;
  logic [DW-1:0] rdata, dq_in, dq_out;

  int cyc_no = 0;
  always @(posedge clk) cyc_no <= cyc_no + 1;

  function automatic logic [DW-1:0] pat(int c);
    return DW'(c * 965) ^ 16'h5A5A;
  endfunction
  assign dq_in = pat(cyc_no);

  nct_top #(.TW(TW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .t_ce_off_rd(ce_rd), .t_ce_off_wr(ce_wr), .t_ale_on(ale_on), .t_ale_off_rd(ale_rd),
    .t_ale_off_wr(ale_wr), .t_oe_on(oe_on), .t_oe_off(oe_off), .t_we_on(we_on), .t_we_off(we_off),
    .t_rd_cycle(rd_cyc), .t_wr_cycle(wr_cyc), .t_rd_access(rd_acc), .t_gap(gap),
    .gap_en(gap_en), .opt_access(opt), .t_turn(turn), .ready(ready), .done(done), .rdata(rdata),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ce_n(ce_n), .ale(ale), .oe_n(oe_n), .we_n(we_n)
  );

  typedef struct {
    int cyc;
    logic ce_n, ale, oe_n, we_n, dq_oe, done, ready;
    logic chk_rd; logic [DW-1:0] rd;
    logic chk_dq; logic [DW-1:0] dq;
    string tag;
  } exp_t;
  exp_t q[$];
  int n_vec = 0, n_bad = 0;

  function automatic logic win(int t, int on, int off);
    return (t >= on) && (t < off);
  endfunction

  function automatic exp_t quiet(int c, logic rdy, string tag);
    exp_t e;
    e.cyc = c; e.ce_n = 1; e.ale = 0; e.oe_n = 1; e.we_n = 1; e.dq_oe = 0;
    e.done = 0; e.ready = rdy; e.chk_rd = 0; e.rd = '0; e.chk_dq = 0; e.dq = '0; e.tag = tag;
    return e;
  endfunction

  task automatic field(string req, string tag, string nm, logic [DW-1:0] a, logic [DW-1:0] x, ref logic bad);
    if (a !== x) begin
      $display("FAIL %s (%s) %s actual=%h expected=%h cycle=%0d", req, tag, nm, a, x, cyc_no);
      bad = 1'b1;
    end
  endtask

  // monitor: compares queued expectations in their cycle
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc_no) begin
      exp_t e; logic bad;
      e = q.pop_front(); bad = 1'b0; n_vec++;
      field("R2", e.tag, "ce_n",  DW'(ce_n),  DW'(e.ce_n),  bad);
      field("R3", e.tag, "ale",   DW'(ale),   DW'(e.ale),   bad);
      field("R4", e.tag, "oe_n",  DW'(oe_n),  DW'(e.oe_n),  bad);
      field("R4", e.tag, "we_n",  DW'(we_n),  DW'(e.we_n),  bad);
      field("R8", e.tag, "dq_oe", DW'(dq_oe), DW'(e.dq_oe), bad);
      field("R6", e.tag, "done",  DW'(done),  DW'(e.done),  bad);
      field("R10", e.tag, "ready", DW'(ready), DW'(e.ready), bad);
      if (e.chk_rd) field("R7", e.tag, "rdata", rdata, e.rd, bad);
      if (e.chk_dq) field("R8", e.tag, "dq_out", dq_out, e.dq, bad);
      if (bad) n_bad++;
    end
  end

  // driver: issues one access and queues its expected waveform
  task automatic issue(logic wr, logic [DW-1:0] wd, string tag);
    int k, cyc, g, tr, w;
    exp_t e;
    k   = cyc_no;
    cyc = wr ? int'(wr_cyc) : int'(rd_cyc);
    g   = (gap_en && !opt) ? int'(gap) : 0;
    tr  = wr ? 0 : int'(turn);
    w   = (g > tr) ? g : tr;
    req_valid = 1'b1; req_write = wr; req_wdata = wd;
    for (int t = 0; t < cyc; t++) begin
      e = quiet(k + 1 + t, 1'b0, tag);
      e.ce_n  = !win(t, 0, wr ? int'(ce_wr) : int'(ce_rd));
      e.ale   = win(t, int'(ale_on), wr ? int'(ale_wr) : int'(ale_rd));
      e.oe_n  = !(!wr && win(t, int'(oe_on), int'(oe_off)));
      e.we_n  = !(wr && win(t, int'(we_on), int'(we_off)));
      e.dq_oe = wr;
      e.chk_dq = wr; e.dq = wd;
      q.push_back(e);
    end
    e = quiet(k + 1 + cyc, w == 0, tag);
    e.done = 1'b1;
    e.chk_rd = !wr; e.rd = pat(k + int'(rd_acc));
    q.push_back(e);
    for (int i = 1; i <= w; i++) q.push_back(quiet(k + 1 + cyc + i, i == w, tag));
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc_no < k + 1 + cyc + w) @(negedge clk);
  endtask

  task automatic expect_idle(int n, string tag);
    int c;
    c = cyc_no;
    for (int i = 1; i <= n; i++) q.push_back(quiet(c + i, 1'b1, tag));
    repeat (n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    ce_rd = 4; ce_wr = 4; ale_on = 0; ale_rd = 4; ale_wr = 4;
    oe_on = 1; oe_off = 3; we_on = 1; we_off = 3;
    rd_cyc = 4; wr_cyc = 4; rd_acc = 4; gap = 6; turn = 9; gap_en = 0; opt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc_no);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_idle(3, "R1 reset");
    // default timing: read with turnaround, back-to-back writes
    issue(1'b0, '0, "R7 default read");
    issue(1'b1, 16'h1234, "R8 default write");
    issue(1'b1, 16'hBEEF, "R6 back-to-back write");
    // same-select gap
    gap_en = 1;
    issue(1'b1, 16'hA5C3, "R10 gap write");
    issue(1'b1, 16'h3C5A, "R10 gap write 2");
    // turnaround beats smaller gap, gap beats smaller turnaround
    issue(1'b0, '0, "R10 read turn 9 vs gap 6");
    turn = 3;
    issue(1'b0, '0, "R10 read gap 6 vs turn 3");
    // optimized access removes the gap
    opt = 1;
    issue(1'b1, 16'h0F0F, "R11 opt write");
    issue(1'b1, 16'hF0F0, "R11 opt write 2");
    issue(1'b0, '0, "R11 opt read keeps turn");
    // separate read and write timings
    defaults();
    ce_rd = 6; ce_wr = 3; ale_on = 1; ale_rd = 2; ale_wr = 5;
    oe_on = 2; oe_off = 5; we_on = 1; we_off = 4; rd_cyc = 7; wr_cyc = 6; rd_acc = 6; turn = 0;
    issue(1'b0, '0, "R2 R3 long read");
    issue(1'b1, 16'h5555, "R2 R3 long write");
    // early capture tick
    rd_acc = 1;
    issue(1'b0, '0, "R7 capture tick 1");
    expect_idle(2, "R7 rdata held");
    // empty windows
    oe_on = 3; oe_off = 3; we_on = 4; we_off = 2; ale_on = 2; ale_rd = 1; ale_wr = 2;
    issue(1'b0, '0, "R5 read empty windows");
    issue(1'b1, 16'h9999, "R5 write empty windows");
    // request while busy is ignored
    defaults(); turn = 0;
    fork
      issue(1'b1, 16'h7777, "R9 busy write");
      begin
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    expect_idle(4, "R9 no access started");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule